// File: doc/BRIEF.md
# Shifted-Operand Recompute Adder Checker

This block adds two unsigned operands and checks its own result by doing the work twice on the same adder. The first pass adds the operands as given. The second pass, one cycle later, adds the same operands moved one place to the left. The second sum is moved back and compared with the first. A broken bit position in the adder hits a different bit of the true sum in each pass, so the two passes disagree, and the block raises an error flag next to the delivered sum.

The cost is time, not area. There is one adder, two pass registers and a small comparator, and a result appears at most every second cycle. Operands enter through a valid/ready handshake. The sum and its error flag leave through a second valid/ready handshake. A fault-injection input holds one chosen bit of the internal adder output at a fixed value, so the detection path can be exercised.

Top module: `shiftcheck_adder`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R2: An operand pair is taken on a rising edge where `in_valid` and `in_ready` are both 1. In the cycle that follows, the second pass runs and `in_ready` is 0.
- R3: `out_valid` is 0 in the cycle after acceptance and becomes 1 exactly two edges after the accepting edge.
- R4: With fault injection off during both passes, `out_sum` equals `in_a + in_b` as a DATA_W+1 bit value and `out_err` is 0. This holds for carries out of the top bit as well.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_sum` and `out_err` stay unchanged.
- R6: While a result is held, `in_ready` follows `out_ready`, so a new pair can be taken on the same edge that a result is taken. At full rate, accepts are two cycles apart.
- R7: While `fault_en` is 1, bit `fault_sel` of the internal DATA_W+2 bit adder output is forced to `fault_val` in both passes. Values of `fault_sel` from 0 to DATA_W+1 name a bit, with bit 0 as the LSB.
- R8: `out_sum` is bits DATA_W..0 of the first-pass adder output. `out_err` is 1 when any of these holds: the second-pass LSB is 1; first-pass bit DATA_W+1 is 1; or second-pass bits DATA_W+1..1 differ from first-pass bits DATA_W..0.
- R9: A stuck adder output bit that changes `out_sum` from the true sum always sets `out_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take an operand pair |
| in_a | input | DATA_W | First operand |
| in_b | input | DATA_W | Second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | DATA_W+1 | First-pass sum |
| out_err | output | 1 | Pass disagreement flag |
| fault_en | input | 1 | Enable stuck-bit injection |
| fault_sel | input | SEL_W | Adder output bit to force |
| fault_val | input | 1 | Value forced onto that bit |

## Verification
A bad pass register or a wrong phase shows up on the very next result, two edges after acceptance: a clean add returns a wrong sum or a false error flag. A comparator that misses a lane shows up only when a stuck bit lands on that lane with operands whose true bit differs from the forced value. For that reason the stimulus steps the forced bit across the LSB, middle lanes, the carry bit and the spare top bit, with carrying and non-carrying operands. Handshake errors appear within one cycle as an early `in_ready`, a lost or duplicated result, or a held result that changes under back-pressure.

// File: rtl/shiftcheck_pkg.sv
package shiftcheck_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PASS2 = 2'd1,
    ST_HOLD  = 2'd2
  } sc_state_t;
endpackage

// File: rtl/shiftcheck_operand_sel.sv
module shiftcheck_operand_sel #(
  parameter int DATA_W = 16,
  parameter int SHIFT  = 1,
  localparam int ADD_W = DATA_W + 1 + SHIFT
) (
  input  logic              second_pass,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic [DATA_W-1:0] a_held,
  input  logic [DATA_W-1:0] b_held,
  output logic [ADD_W-1:0]  x,
  output logic [ADD_W-1:0]  y
);
  always_comb begin
    if (second_pass) begin
      x = ADD_W'(a_held) << SHIFT;
      y = ADD_W'(b_held) << SHIFT;
    end else begin
      x = ADD_W'(a_in);
      y = ADD_W'(b_in);
    end
  end
endmodule

// File: rtl/shiftcheck_core_add.sv
module shiftcheck_core_add #(
  parameter int ADD_W = 18,
  parameter int SEL_W = 5
) (
  input  logic [ADD_W-1:0] x,
  input  logic [ADD_W-1:0] y,
  input  logic             fault_en,
  input  logic [SEL_W-1:0] fault_sel,
  input  logic             fault_val,
  output logic [ADD_W-1:0] s
);
  logic [ADD_W-1:0] raw;
  assign raw = x + y;

  for (genvar i = 0; i < ADD_W; i++) begin : g_lane
    assign s[i] = (fault_en && (fault_sel == SEL_W'(i))) ? fault_val : raw[i];
  end
endmodule

// File: rtl/shiftcheck_compare.sv
module shiftcheck_compare #(
  parameter int DATA_W = 16,
  parameter int SHIFT  = 1,
  localparam int ADD_W = DATA_W + 1 + SHIFT
) (
  input  logic [ADD_W-1:0] first_sum,
  input  logic [ADD_W-1:0] second_sum,
  output logic             mismatch
);
  logic low_dirty;
  logic top_dirty;
  logic body_diff;

  assign low_dirty = |second_sum[SHIFT-1:0];
  assign top_dirty = |first_sum[ADD_W-1:DATA_W+1];
  assign body_diff = second_sum[ADD_W-1:SHIFT] != first_sum[DATA_W:0];
  assign mismatch  = low_dirty | top_dirty | body_diff;
endmodule

// File: rtl/shiftcheck_adder.sv
module shiftcheck_adder #(
  parameter int DATA_W = 16,
  localparam int SHIFT = 1,
  localparam int ADD_W = DATA_W + 1 + SHIFT,
  localparam int SEL_W = $clog2(ADD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W:0]   out_sum,
  output logic              out_err,
  input  logic              fault_en,
  input  logic [SEL_W-1:0]  fault_sel,
  input  logic              fault_val
);
  import shiftcheck_pkg::*;

  sc_state_t         state_q;
  logic [DATA_W-1:0] a_q, b_q;
  logic [ADD_W-1:0]  first_q;
  logic [ADD_W-1:0]  op_x, op_y, add_s;
  logic              mismatch;
  logic              take_in;
  logic              second_pass;

  assign in_ready    = (state_q == ST_IDLE) || ((state_q == ST_HOLD) && out_ready);
  assign take_in     = in_valid && in_ready;
  assign second_pass = (state_q == ST_PASS2);

  shiftcheck_operand_sel #(.DATA_W(DATA_W), .SHIFT(SHIFT)) u_sel (
    .second_pass(second_pass),
    .a_in(in_a),
    .b_in(in_b),
    .a_held(a_q),
    .b_held(b_q),
    .x(op_x),
    .y(op_y)
  );

  shiftcheck_core_add #(.ADD_W(ADD_W), .SEL_W(SEL_W)) u_add (
    .x(op_x),
    .y(op_y),
    .fault_en(fault_en),
    .fault_sel(fault_sel),
    .fault_val(fault_val),
    .s(add_s)
  );

  shiftcheck_compare #(.DATA_W(DATA_W), .SHIFT(SHIFT)) u_cmp (
    .first_sum(first_q),
    .second_sum(add_s),
    .mismatch(mismatch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      a_q       <= '0;
      b_q       <= '0;
      first_q   <= '0;
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_err   <= 1'b0;
    end else if (take_in) begin
      a_q       <= in_a;
      b_q       <= in_b;
      first_q   <= add_s;
      out_valid <= 1'b0;
      state_q   <= ST_PASS2;
    end else if (second_pass) begin
      out_sum   <= first_q[DATA_W:0];
      out_err   <= mismatch;
      out_valid <= 1'b1;
      state_q   <= ST_HOLD;
    end else if ((state_q == ST_HOLD) && out_ready) begin
      out_valid <= 1'b0;
      state_q   <= ST_IDLE;
    end
  end
endmodule

// File: rtl/shiftcheck_adder_chk.sv
module shiftcheck_adder_chk #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W:0]   out_sum,
  input logic              out_err,
  input logic              fault_en,
  input logic [SEL_W-1:0]  fault_sel,
  input logic              fault_val
);
  logic fire;
  assign fire = in_valid && in_ready;

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!out_valid && in_ready));

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> !in_ready);

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> (!out_valid ##1 out_valid));

  // R4
  clean_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    ((fire && !fault_en) ##1 !fault_en) |=> !out_err);

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_err)));

  // R6
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |-> in_ready);

  // R9
  no_silent_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> ##2 (out_err ||
      (out_sum == ({1'b0, $past(in_a, 2)} + {1'b0, $past(in_b, 2)}))));

  logic unused_ok;
  assign unused_ok = ^{fault_sel, fault_val};
endmodule

bind shiftcheck_adder shiftcheck_adder_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk),
  .rst(rst),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .in_a(in_a),
  .in_b(in_b),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_sum(out_sum),
  .out_err(out_err),
  .fault_en(fault_en),
  .fault_sel(fault_sel),
  .fault_val(fault_val)
);

// File: tb/shiftcheck_adder_bench.sv
module shiftcheck_adder_bench;
  localparam int N  = 16;
  localparam int AW = N + 2;
  localparam int SW = $clog2(AW);

  typedef struct packed {
    logic [N:0] sum;
    logic       err;
    logic [N:0] truth;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [N-1:0]  in_a = '0, in_b = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [N:0]    out_sum;
  logic          out_err;
  logic          fault_en = 1'b0;
  logic [SW-1:0] fault_sel = '0;
  logic          fault_val = 1'b0;

  int   total = 0;
  int   bad   = 0;
  int   cyc   = 0;
  int   last_take = 0;
  int   prev_take = 0;
  logic stall_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  exp_t sb[$];

  shiftcheck_adder #(.DATA_W(N)) u_shiftcheck_adder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum), .out_err(out_err), .fault_en(fault_en),
    .fault_sel(fault_sel), .fault_val(fault_val)
  );

  always #2 clk = ~clk;

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      total++; bad++;
      $display("FAIL watchdog: cycles=%0d expected=<20000", cyc);
      report();
      $finish;
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= stall_mode ? lfsr[0] : 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [N-1:0] a, input logic [N-1:0] b,
                                 input logic fe, input logic [SW-1:0] fs, input logic fv);
    logic [AW-1:0] t, t2, p1, p2;
    exp_t e;
    t  = AW'(a) + AW'(b);
    t2 = t << 1;
    p1 = t;
    p2 = t2;
    if (fe && (int'(fs) < AW)) begin
      p1[fs] = fv;
      p2[fs] = fv;
    end
    e.sum   = p1[N:0];
    e.err   = (p1 != t) || (p2 != t2);
    e.truth = t[N:0];
    return e;
  endfunction

  // Monitor: pops the scoreboard on each taken result; checks R4/R7/R8/R9 and R5
  logic       hold_prev = 1'b0;
  logic [N:0] sum_prev;
  logic       err_prev;
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_prev) begin
        check("R5 hold valid", 32'(out_valid), 32'd1);
        check("R5 hold sum", 32'(out_sum), 32'(sum_prev));
        check("R5 hold err", 32'(out_err), 32'(err_prev));
      end
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check("R3 unexpected result", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check("R4/R7/R8 sum", 32'(out_sum), 32'(e.sum));
          check("R8 err", 32'(out_err), 32'(e.err));
          if (!out_err) check("R9 silent", 32'(out_sum), 32'(e.truth));
        end
      end
      hold_prev <= out_valid && !out_ready;
      sum_prev  <= out_sum;
      err_prev  <= out_err;
    end
  end

  // Driver: called just after a falling edge; returns after the second pass edge
  task automatic send(input logic [N-1:0] a, input logic [N-1:0] b,
                      input logic fe, input logic [SW-1:0] fs, input logic fv);
    in_a = a; in_b = b; fault_en = fe; fault_sel = fs; fault_val = fv;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    prev_take = last_take;
    last_take = cyc;
    sb.push_back(model(a, b, fe, fs, fv));
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 busy in pass two", 32'(in_ready), 32'd0);
    check("R3 no early result", 32'(out_valid), 32'd0);
    @(negedge clk);
    check("R3 result after two edges", 32'(out_valid), 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 out_valid after reset", 32'(out_valid), 32'd0);
    check("R1 in_ready after reset", 32'(in_ready), 32'd1);

    // R4: clean adds, back to back
    send(16'h0000, 16'h0000, 1'b0, '0, 1'b0);
    send(16'h1234, 16'h4321, 1'b0, '0, 1'b0);
    send(16'hFFFF, 16'hFFFF, 1'b0, '0, 1'b0);
    send(16'hAAAA, 16'h5555, 1'b0, '0, 1'b0);
    send(16'h8000, 16'h8000, 1'b0, '0, 1'b0);
    // R6: full-rate accept spacing
    check("R6 accept spacing", 32'(last_take - prev_take), 32'd2);

    // R7/R8/R9: stuck bits across lanes
    send(16'h0001, 16'h0000, 1'b1, SW'(0), 1'b0);
    send(16'h0000, 16'h0000, 1'b1, SW'(0), 1'b1);
    send(16'h0000, 16'h0000, 1'b1, SW'(0), 1'b0);
    send(16'h0003, 16'h0000, 1'b1, SW'(1), 1'b0);
    send(16'h00F0, 16'h0010, 1'b1, SW'(8), 1'b1);
    send(16'h0100, 16'h0000, 1'b1, SW'(8), 1'b1);
    send(16'hFFFF, 16'hFFFF, 1'b1, SW'(N), 1'b0);
    send(16'h0001, 16'h0001, 1'b1, SW'(N), 1'b0);
    send(16'hFFFF, 16'h0001, 1'b1, SW'(N + 1), 1'b0);
    send(16'h0001, 16'h0001, 1'b1, SW'(N + 1), 1'b1);
    send(16'h0001, 16'h0001, 1'b1, SW'(N + 1), 1'b0);
    for (int k = 0; k < AW; k++) begin
      send(16'h5A3C, 16'h0F0F, 1'b1, SW'(k), k[0]);
    end

    // R5/R6 under back-pressure
    stall_mode = 1'b1;
    for (int i = 0; i < 24; i++) begin
      send(N'(i * 16'h0931), N'(16'hF00F ^ (i * 16'h0107)), i[2], SW'(i % AW), i[0]);
    end
    stall_mode = 1'b0;

    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R3 no stray result", 32'(out_valid), 32'd0);
    report();
    $finish;
  end
endmodule